// File: doc/BRIEF.md
# Converter Sequencer with Quiet-Conversion Core Stall

This block sits between a processor's register bus and a two-input analog-to-digital converter. It derives the converter's clock-enable from the peripheral clock through a programmable even divider. It steers one of two analog inputs to the converter and applies the power-up settling delay. It launches conversions when software asks for one, and it captures the digital result when the converter reports completion. The analog conversion itself is modelled as a start pulse answered later by a done strobe that carries the result.

Software may set a quiet-conversion bit in the same write that requests a conversion. While such a conversion runs, the block holds the processor core through a stall output. Every interrupt request that arrives in that window is kept back and presented again once the conversion has finished, so the interrupt controller can serve the requests in its own priority order. Peripheral logic is never gated by the stall. The quiet bit clears itself when the result arrives.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The register map is: address 0 control, address 1 divider code (5 bits), address 2 settling count, address 3 result bits 7:0, address 4 result bits 9:8; other addresses read zero. The control bits are: bit0 power, bit1 input select, bit2 quiet, bit3 start (write-only, reads 0), bit4 busy (read-only), bit5 end-of-conversion flag, bit6 early-start error flag.
- R2: While the power bit is set, `conv_clk_en` pulses once every 2×D peripheral clock cycles, where D is the divider code and a code of 0 counts as 32 (a period of 64). While power is clear, it stays low.
- R3: When the power bit goes from 0 to 1, the settling count is loaded. A start request is refused until that many `conv_clk_en` pulses have passed, or while power is clear. A refused start sets the sticky error bit, and writing 0 to bit6 clears it.
- R4: An accepted start raises `conv_start` for exactly one cycle, in the cycle after the write, and busy reads 1 from that cycle until the cycle after the `conv_done` strobe.
- R5: A `conv_done` strobe during busy stores `conv_result` and sets the end-of-conversion flag, and writing 0 to bit5 clears the flag. A `conv_done` strobe while idle changes neither the result nor the flag.
- R6: `cpu_stall` is high from the cycle after an accepted start that had the quiet bit set (a single write may set both), until the cycle after `conv_done`. It never rises for a conversion started with quiet clear.
- R7: The quiet bit reads 0 after the conversion ends. A write to it while busy is ignored.
- R8: While `cpu_stall` is high, `irq_out` is all zero, and every `irq_in` line that pulses in that window is presented on `irq_out` for one cycle in the first cycle after the stall drops. Without a stall, `irq_out` equals `irq_in` in the same cycle.
- R9: `conv_chan` follows the input select bit (0 selects input 0, 1 selects input 1). Changes to the input select and the divider code that are written while busy are held, and they take effect at `conv_done`.
- R10: A start request made while busy is ignored and does not set the error bit.
- R11: After reset every register reads 0, and `conv_start`, `cpu_stall`, `conv_clk_en` and `irq_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Register read data (combinational) |
| conv_clk_en | output | 1 | Converter clock-enable pulse |
| conv_power | output | 1 | Converter power enable |
| conv_chan | output | 1 | Selected analog input |
| conv_start | output | 1 | One-cycle conversion launch |
| conv_done | input | 1 | Conversion complete strobe |
| conv_result | input | RES_W | Conversion result, valid with conv_done |
| cpu_stall | output | 1 | Core hold during a quiet conversion |
| irq_in | input | IRQ_N | Interrupt requests from the system |
| irq_out | output | IRQ_N | Interrupt requests toward the interrupt controller |

## Verification
The hardest situation to reach is a quiet conversion during which other traffic arrives. In that window an interrupt pulse must be parked, the divider and input-select writes must be queued, and a second start must be refused without an error. After all of that, the done strobe has to release everything in a single cycle. The stimulus launches a quiet conversion and holds back the done strobe. It fires an interrupt pulse, queues a new divider code and input select, and repeats the start request, all before it issues the done strobe. A behavioural model that runs in step with the design then checks the released pulse, the applied settings and the new tick period on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   // register addresses
   localparam int ADR_CTRL  = 0;
   localparam int ADR_DIV   = 1;
   localparam int ADR_SETUP = 2;
   localparam int ADR_RESLO = 3;
   localparam int ADR_RESHI = 4;
   // control register bit positions
   localparam int B_PWR   = 0;
   localparam int B_CHAN  = 1;
   localparam int B_QUIET = 2;
   localparam int B_GO    = 3;
   localparam int B_BUSY  = 4;
   localparam int B_EOC   = 5;
   localparam int B_ERR   = 6;
   localparam int CTRL_BITS = 7;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] code,
   output logic             tick
);
   localparam int CNT_W   = DIV_W + 2;
   localparam int MAX_DIV = 2 ** (DIV_W + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim;

   always_comb begin
      if (code == '0) lim = CNT_W'(MAX_DIV - 1);
      else            lim = {1'b0, code, 1'b0} - CNT_W'(1);
   end

   assign tick = en && (cnt_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt_q <= '0;
      else if (!en)      cnt_q <= '0;
      else if (tick)     cnt_q <= '0;
      else               cnt_q <= cnt_q + CNT_W'(1);
   end

   // R2
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
   // R2
   tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> (cnt_q == '0));
endmodule

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
   parameter int SETUP_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               powered,
   input  logic               load,
   input  logic [SETUP_W-1:0] load_val,
   input  logic               tick,
   output logic               ready
);
   logic [SETUP_W-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      left_q <= '0;
      else if (load)                   left_q <= load_val;
      else if (tick && left_q != '0)   left_q <= left_q - SETUP_W'(1);
   end

   assign ready = powered && (left_q == '0);

   // R3
   settle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !ready);
endmodule

// File: rtl/adc_seq_irqgate.sv
module adc_seq_irqgate #(
   parameter int IRQ_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stall,
   input  logic [IRQ_N-1:0] irq_in,
   output logic [IRQ_N-1:0] irq_out
);
   for (genvar i = 0; i < IRQ_N; i++) begin : g_line
      logic held_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     held_q <= 1'b0;
         else if (stall) held_q <= held_q | irq_in[i];
         else            held_q <= 1'b0;
      end

      assign irq_out[i] = stall ? 1'b0 : (irq_in[i] | held_q);

      // R8
      irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (stall && irq_in[i]) |=> (stall || irq_out[i]));
   end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 8,
   parameter int DIV_W   = 5,
   parameter int SETUP_W = 8,
   parameter int RES_W   = 10,
   parameter int IRQ_N   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              conv_clk_en,
   output logic              conv_power,
   output logic              conv_chan,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [RES_W-1:0]  conv_result,
   output logic              cpu_stall,
   input  logic [IRQ_N-1:0]  irq_in,
   output logic [IRQ_N-1:0]  irq_out
);
   localparam int WIDE_W = 2 * DATA_W;

   initial begin : param_chk
      assert (DATA_W >= CTRL_BITS) else $error("DATA_W too narrow for control bits");
      assert (DIV_W <= DATA_W)     else $error("DIV_W exceeds DATA_W");
      assert (SETUP_W <= DATA_W)   else $error("SETUP_W exceeds DATA_W");
      assert (RES_W <= WIDE_W)     else $error("RES_W exceeds two data words");
      assert (IRQ_N >= 1)          else $error("IRQ_N must be positive");
      assert (ADDR_W >= 3)         else $error("ADDR_W too narrow for map");
   end

   // state
   logic               pwr_q, quiet_q, busy_q, eoc_q, err_q, start_q;
   logic               chan_q, chan_p_q, chan_pv_q;
   logic [DIV_W-1:0]   div_q, div_p_q;
   logic               div_pv_q;
   logic [SETUP_W-1:0] setup_q;
   logic [RES_W-1:0]   result_q;

   // decode
   logic wr_ctrl, wr_div, wr_setup;
   logic start_req, accept, start_err, done_ev, pwr_rise;
   logic ready, tick;
   logic               chan_p_nx, chan_pv_nx, div_pv_nx;
   logic [DIV_W-1:0]   div_p_nx;

   assign wr_ctrl  = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
   assign wr_div   = wr_en && (wr_addr == ADDR_W'(ADR_DIV));
   assign wr_setup = wr_en && (wr_addr == ADDR_W'(ADR_SETUP));

   assign start_req = wr_ctrl && wr_data[B_GO];
   assign accept    = start_req && !busy_q && ready;
   assign start_err = start_req && !busy_q && !ready;
   assign done_ev   = busy_q && conv_done;
   assign pwr_rise  = wr_ctrl && wr_data[B_PWR] && !pwr_q;

   // settings written during a conversion, merged with this cycle's write
   assign chan_p_nx  = (wr_ctrl && busy_q) ? wr_data[B_CHAN] : chan_p_q;
   assign chan_pv_nx = (wr_ctrl && busy_q) || chan_pv_q;
   assign div_p_nx   = (wr_div && busy_q) ? wr_data[DIV_W-1:0] : div_p_q;
   assign div_pv_nx  = (wr_div && busy_q) || div_pv_q;

   adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (pwr_q),
      .code (div_q),
      .tick (tick)
   );

   adc_seq_settle #(.SETUP_W(SETUP_W)) u_settle (
      .clk     (clk),
      .rst_n   (rst_n),
      .powered (pwr_q),
      .load    (pwr_rise),
      .load_val(setup_q),
      .tick    (tick),
      .ready   (ready)
   );

   adc_seq_irqgate #(.IRQ_N(IRQ_N)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stall  (cpu_stall),
      .irq_in (irq_in),
      .irq_out(irq_out)
   );

   // sequencing state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr_q   <= 1'b0;
         busy_q  <= 1'b0;
         start_q <= 1'b0;
         quiet_q <= 1'b0;
      end else begin
         start_q <= accept;
         if (wr_ctrl) pwr_q <= wr_data[B_PWR];
         if (done_ev)      busy_q <= 1'b0;
         else if (accept)  busy_q <= 1'b1;
         if (done_ev)                 quiet_q <= 1'b0;
         else if (wr_ctrl && !busy_q) quiet_q <= wr_data[B_QUIET];
      end
   end

   // flags and result
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eoc_q    <= 1'b0;
         err_q    <= 1'b0;
         result_q <= '0;
      end else begin
         if (done_ev)                        eoc_q <= 1'b1;
         else if (wr_ctrl && !wr_data[B_EOC]) eoc_q <= 1'b0;
         if (start_err)                      err_q <= 1'b1;
         else if (wr_ctrl && !wr_data[B_ERR]) err_q <= 1'b0;
         if (done_ev) result_q <= conv_result;
      end
   end

   // input select and divider, with deferral during a conversion
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q    <= 1'b0;
         chan_p_q  <= 1'b0;
         chan_pv_q <= 1'b0;
         div_q     <= '0;
         div_p_q   <= '0;
         div_pv_q  <= 1'b0;
         setup_q   <= '0;
      end else begin
         if (wr_setup) setup_q <= wr_data[SETUP_W-1:0];
         if (done_ev) begin
            if (chan_pv_nx) chan_q <= chan_p_nx;
            if (div_pv_nx)  div_q  <= div_p_nx;
            chan_pv_q <= 1'b0;
            div_pv_q  <= 1'b0;
         end else begin
            chan_p_q  <= chan_p_nx;
            chan_pv_q <= chan_pv_nx;
            div_p_q   <= div_p_nx;
            div_pv_q  <= div_pv_nx;
            if (wr_ctrl && !busy_q) chan_q <= wr_data[B_CHAN];
            if (wr_div && !busy_q)  div_q  <= wr_data[DIV_W-1:0];
         end
      end
   end

   assign conv_clk_en = tick;
   assign conv_power  = pwr_q;
   assign conv_chan   = chan_q;
   assign conv_start  = start_q;
   assign cpu_stall   = busy_q && quiet_q;

   // read path
   logic [DATA_W-1:0] ctrl_rd, div_rd, setup_rd;
   logic [WIDE_W-1:0] res_wide;

   always_comb begin
      ctrl_rd          = '0;
      ctrl_rd[B_PWR]   = pwr_q;
      ctrl_rd[B_CHAN]  = chan_q;
      ctrl_rd[B_QUIET] = quiet_q;
      ctrl_rd[B_BUSY]  = busy_q;
      ctrl_rd[B_EOC]   = eoc_q;
      ctrl_rd[B_ERR]   = err_q;
      div_rd                 = '0;
      div_rd[DIV_W-1:0]      = div_q;
      setup_rd               = '0;
      setup_rd[SETUP_W-1:0]  = setup_q;
      res_wide               = '0;
      res_wide[RES_W-1:0]    = result_q;
   end

   always_comb begin
      case (rd_addr)
         ADDR_W'(ADR_CTRL):  rd_data = ctrl_rd;
         ADDR_W'(ADR_DIV):   rd_data = div_rd;
         ADDR_W'(ADR_SETUP): rd_data = setup_rd;
         ADDR_W'(ADR_RESLO): rd_data = res_wide[DATA_W-1:0];
         ADDR_W'(ADR_RESHI): rd_data = res_wide[WIDE_W-1:DATA_W];
         default:            rd_data = '0;
      endcase
   end

   // R3
   start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> $past(ready));
   // R4
   start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   // R4
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy_q);
   // R5
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && conv_done) |=> (eoc_q && !busy_q));
   // R7
   quiet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && conv_done) |=> !quiet_q);
   // R9
   chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done) |=> $stable(conv_chan));
   // R5
   idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && conv_done) |=> $stable(result_q));
endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
   localparam int ADDR_W = 3, DATA_W = 8, RES_W = 10, IRQ_N = 4;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
   logic [DATA_W-1:0] wr_data = '0, rd_data;
   logic conv_clk_en, conv_power, conv_chan, conv_start, cpu_stall;
   logic conv_done = 1'b0;
   logic [RES_W-1:0] conv_result = '0;
   logic [IRQ_N-1:0] irq_in = '0, irq_out;

   int n_chk = 0, n_fail = 0, cyc = 0;

   always #5 clk = ~clk;

   adc_seq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .conv_clk_en(conv_clk_en),
      .conv_power(conv_power), .conv_chan(conv_chan), .conv_start(conv_start),
      .conv_done(conv_done), .conv_result(conv_result), .cpu_stall(cpu_stall),
      .irq_in(irq_in), .irq_out(irq_out)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // behavioural reference model
   int m_pwr, m_chan, m_quiet, m_busy, m_eoc, m_err, m_start;
   int m_div, m_setup, m_res, m_dcnt, m_scnt, m_held;
   int m_cp, m_cpv, m_dp, m_dpv;

   function automatic int m_period();
      return (m_div == 0) ? 64 : 2 * m_div;
   endfunction
   function automatic int m_tick();
      return (m_pwr != 0 && m_dcnt >= m_period() - 1) ? 1 : 0;
   endfunction
   function automatic int m_stall();
      return (m_busy != 0 && m_quiet != 0) ? 1 : 0;
   endfunction
   function automatic int m_read(input int a);
      case (a)
         0: return m_pwr | (m_chan << 1) | (m_quiet << 2) | (m_busy << 4) | (m_eoc << 5) | (m_err << 6);
         1: return m_div;
         2: return m_setup;
         3: return m_res & 255;
         4: return m_res >> 8;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int tk, rdy, done, acc, serr, wc, wd, ws, prise, stl;
      if (!rst_n) begin
         m_pwr = 0; m_chan = 0; m_quiet = 0; m_busy = 0; m_eoc = 0; m_err = 0; m_start = 0;
         m_div = 0; m_setup = 0; m_res = 0; m_dcnt = 0; m_scnt = 0; m_held = 0;
         m_cp = 0; m_cpv = 0; m_dp = 0; m_dpv = 0;
      end else begin
         tk    = m_tick();
         rdy   = (m_pwr != 0 && m_scnt == 0) ? 1 : 0;
         stl   = m_stall();
         wc    = (wr_en && wr_addr == 0) ? 1 : 0;
         wd    = (wr_en && wr_addr == 1) ? 1 : 0;
         ws    = (wr_en && wr_addr == 2) ? 1 : 0;
         done  = (m_busy != 0 && conv_done) ? 1 : 0;
         acc   = (wc != 0 && wr_data[3] && m_busy == 0 && rdy != 0) ? 1 : 0;
         serr  = (wc != 0 && wr_data[3] && m_busy == 0 && rdy == 0) ? 1 : 0;
         prise = (wc != 0 && wr_data[0] && m_pwr == 0) ? 1 : 0;
         m_held = (stl != 0) ? (m_held | int'(irq_in)) : 0;
         if (m_pwr == 0 || tk != 0) m_dcnt = 0; else m_dcnt++;
         if (prise != 0) m_scnt = m_setup;
         else if (tk != 0 && m_scnt > 0) m_scnt--;
         if (wc != 0 && m_busy != 0) begin m_cp = int'(wr_data[1]); m_cpv = 1; end
         if (wd != 0 && m_busy != 0) begin m_dp = int'(wr_data[4:0]); m_dpv = 1; end
         if (done != 0) begin
            if (m_cpv != 0) m_chan = m_cp;
            if (m_dpv != 0) m_div = m_dp;
            m_cpv = 0; m_dpv = 0;
         end
         if (wc != 0 && m_busy == 0) m_chan = int'(wr_data[1]);
         if (wd != 0 && m_busy == 0) m_div = int'(wr_data[4:0]);
         if (ws != 0) m_setup = int'(wr_data);
         m_start = acc;
         if (done != 0) m_quiet = 0;
         else if (wc != 0 && m_busy == 0) m_quiet = int'(wr_data[2]);
         if (done != 0) m_eoc = 1;
         else if (wc != 0 && !wr_data[5]) m_eoc = 0;
         if (serr != 0) m_err = 1;
         else if (wc != 0 && !wr_data[6]) m_err = 0;
         if (done != 0) m_res = int'(conv_result);
         if (wc != 0) m_pwr = int'(wr_data[0]);
         if (done != 0) m_busy = 0;
         else if (acc != 0) m_busy = 1;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2 conv_clk_en", 32'(conv_clk_en), 32'(m_tick()));
         chk("R4 conv_start", 32'(conv_start), 32'(m_start));
         chk("R9 conv_chan", 32'(conv_chan), 32'(m_chan));
         chk("R3 conv_power", 32'(conv_power), 32'(m_pwr));
         chk("R6 cpu_stall", 32'(cpu_stall), 32'(m_stall()));
         chk("R8 irq_out", 32'(irq_out), (m_stall() != 0) ? 32'd0 : 32'(int'(irq_in) | m_held));
         chk("R1 rd_data", 32'(rd_data), 32'(m_read(int'(rd_addr))));
      end
   end

   // free-running read address
   always @(posedge clk) begin
      #2 rd_addr <= (rd_addr >= 3'd4) ? 3'd0 : rd_addr + 3'd1;
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected under 20000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(posedge clk); #2;
      wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = DATA_W'(d);
      @(posedge clk); #2;
      wr_en = 1'b0;
   endtask

   task automatic done_pulse(input int v);
      @(posedge clk); #2;
      conv_done = 1'b1; conv_result = RES_W'(v);
      @(posedge clk); #2;
      conv_done = 1'b0;
   endtask

   task automatic rd_chk(input int a, input int exp, input string tag);
      @(negedge clk);
      while (rd_addr != ADDR_W'(a)) @(negedge clk);
      chk(tag, 32'(rd_data), 32'(exp));
   endtask

   task automatic count_ticks(input int n, output int got);
      got = 0;
      repeat (n) begin
         @(negedge clk);
         if (conv_clk_en) got++;
      end
   endtask

   initial begin
      int t;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R11 reset state
      rd_chk(0, 0, "R11 ctrl after reset");
      rd_chk(4, 0, "R11 result after reset");
      chk("R11 stall after reset", 32'(cpu_stall), 0);
      chk("R11 start after reset", 32'(conv_start), 0);
      chk("R11 tick after reset", 32'(conv_clk_en), 0);

      // settling and early start (R3)
      wr(1, 2);
      wr(2, 3);
      rd_chk(1, 2, "R1 divider readback");
      wr(0, 8'h01);
      wr(0, 8'h09);
      rd_chk(0, 8'h41, "R3 early start sets error");
      wr(0, 8'h01);
      rd_chk(0, 8'h01, "R3 error cleared by zero write");
      repeat (20) @(posedge clk);

      // plain conversion (R4, R5)
      wr(0, 8'h09);
      @(negedge clk);
      chk("R4 start pulse", 32'(conv_start), 1);
      chk("R6 no stall without quiet", 32'(cpu_stall), 0);
      rd_chk(0, 8'h11, "R4 busy reads 1");
      done_pulse(10'h2A5);
      rd_chk(0, 8'h21, "R5 eoc set, busy clear");
      rd_chk(3, 8'hA5, "R5 result low");
      rd_chk(4, 8'h02, "R5 result high");
      wr(0, 8'h01);
      rd_chk(0, 8'h01, "R5 eoc cleared");

      // quiet conversion with traffic (R6..R10, R2)
      wr(0, 8'h0F);
      @(negedge clk);
      chk("R6 stall in quiet conversion", 32'(cpu_stall), 1);
      chk("R9 input 1 selected", 32'(conv_chan), 1);
      @(posedge clk); #2 irq_in = 4'b0010;
      @(posedge clk); #2 irq_in = 4'b0000;
      @(negedge clk);
      chk("R8 irq held during stall", 32'(irq_out), 0);
      wr(1, 5);
      wr(0, 8'h01);
      wr(0, 8'h09);
      @(negedge clk);
      chk("R9 select held while busy", 32'(conv_chan), 1);
      rd_chk(0, 8'h17, "R10 busy start no error, R7 quiet kept");
      rd_chk(1, 2, "R9 divider held while busy");
      done_pulse(10'h1C3);
      @(negedge clk);
      chk("R8 held irq released", 32'(irq_out), 4'b0010);
      chk("R6 stall drops after done", 32'(cpu_stall), 0);
      chk("R9 select applied at done", 32'(conv_chan), 0);
      @(negedge clk);
      chk("R8 release lasts one cycle", 32'(irq_out), 0);
      rd_chk(0, 8'h21, "R7 quiet self-cleared");
      rd_chk(1, 5, "R9 divider applied at done");

      // done while idle (R5)
      wr(0, 8'h01);
      done_pulse(10'h155);
      rd_chk(0, 8'h01, "R5 idle done leaves eoc clear");
      rd_chk(3, 8'hC3, "R5 idle done leaves result");

      // divide-by-64 (R2)
      wr(1, 0);
      @(negedge clk);
      while (!conv_clk_en) @(negedge clk);
      count_ticks(256, t);
      chk("R2 code 0 gives period 64", 32'(t), 4);

      // power off (R2) and irq pass-through (R8)
      wr(0, 8'h00);
      count_ticks(100, t);
      chk("R2 no ticks while off", 32'(t), 0);
      @(posedge clk); #2 irq_in = 4'b0101;
      @(negedge clk);
      chk("R8 pass-through without stall", 32'(irq_out), 4'b0101);
      @(posedge clk); #2 irq_in = 4'b0000;

      // non-quiet conversion on input 1 (R6, R9)
      wr(0, 8'h01);
      repeat (200) @(posedge clk);
      wr(0, 8'h0B);
      @(negedge clk);
      chk("R6 no stall with quiet clear", 32'(cpu_stall), 0);
      chk("R9 input 1 for conversion", 32'(conv_chan), 1);
      done_pulse(10'h3FF);
      rd_chk(0, 8'h23, "R5 eoc after second conversion");
      rd_chk(4, 8'h03, "R5 result high all ones");
      rd_chk(2, 3, "R1 settling readback");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule